// File: doc/BRIEF.md
# Counter Waveform Generator with Deferred Register Update

This block drives a single output pin from an up-counter that runs from zero to a programmable period value and wraps. A compare value sets where inside each period the output turns active. Three waveform styles are available. Continuous PWM repeats every period. A single pulse runs for exactly one period and then stops. In set-once mode the output latches active at the first compare match and keeps that level. Which style runs depends on a mode bit and on which of the two start strobes launched the run.

Software programs the block through a small write port. Address 0 is the period, address 1 is the compare value, and address 2 is configuration. An enable input gates the counter. Clearing the enable stops the run and flushes its state. An output polarity bit inverts the pin on the next clock, whether or not a run is active. A deferral bit holds new period and compare values in shadow registers while a run is in progress and copies them to the working registers only at the end of the period.

Top module: `tmr_wave_gen`

## Requirements
- R1: Writes with `wrEn` high go to address 0 (period), 1 (compare) or 2 (configuration: bit 0 set-once mode, bit 1 invert, bit 2 defer). In mode 0, a run started by `startCont` makes the counter step 0,1,..,period,0,... one value per clock. `waveOut` is registered, and after the clock that processes count value c it is active when c > compare.
- R2: A run started by `startSingle` in mode 0 covers exactly one period with the R1 timing. The counter then stops at 0, and `waveOut` returns to its inactive level until the next start.
- R3: In set-once mode, `waveOut` turns active one clock after the first count value above compare. It then stays active across every later wrap.
- R4: The invert bit XORs `waveOut`. A change takes effect on the clock edge after the edge that writes it, including while `enable` is low.
- R5: With the defer bit clear, a compare or period write made during a run is used from the count value that follows the write edge.
- R6: With the defer bit set and a run active, written period or compare values take effect only after the wrap of the current period. The edge that processes count value period still uses the old values.
- R7: While no run is active, period and compare writes take effect at once, whatever the defer bit says.
- R8: When compare is greater than or equal to period, `waveOut` stays inactive for the whole period.
- R9: A period value of 0 is treated as 1, so the shortest period is two clocks.
- R10: Holding `enable` low stops the run, clears the counter, clears the set-once latch and discards any deferred update. `waveOut` goes inactive on the second edge after `enable` falls.
- R11: Start strobes have no effect while `enable` is low.
- R12: After reset, `waveOut` is 0 and the period, compare and configuration registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Counter enable; low stops and flushes the run |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 period, 1 compare, 2 configuration |
| wrData | input | CNT_W | Write data |
| startCont | input | 1 | Start a continuous run |
| startSingle | input | 1 | Start a one-period run |
| waveOut | output | 1 | Registered waveform output |

## Verification
The bench builds the block with `CNT_W` = 8. With that width, periods of a handful of clocks make every wrap, every deferred transfer and every set-once latch visible within a few dozen cycles. A compare value of 200 is also legal at that width, which covers the case of a compare far above the period. Period 0 exercises the clamp to the two-clock minimum.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;

  typedef struct packed {
    logic cntClear;   // force counter to zero
    logic cntInc;     // advance counter
    logic periodEnd;  // last count of a running period
    logic running;    // a run is in progress
    logic flush;      // enable is low
  } wave_strobe_t;

  localparam logic [1:0] ADDR_PERIOD  = 2'd0;
  localparam logic [1:0] ADDR_COMPARE = 2'd1;
  localparam logic [1:0] ADDR_CONFIG  = 2'd2;

  localparam int CFG_W        = 3;
  localparam int CFG_MODE_BIT = 0;
  localparam int CFG_POL_BIT  = 1;
  localparam int CFG_PRE_BIT  = 2;

endpackage

// File: rtl/tmr_wave_ctrl.sv
module tmr_wave_ctrl
  import tmr_wave_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         startCont,
  input  logic         startSingle,
  input  logic         wrapHit,
  output wave_strobe_t strobe,
  output logic         singleRun
);

  logic running;
  logic startAny;
  logic endHit;

  assign startAny = enable && !running && (startCont || startSingle);
  assign endHit   = running && wrapHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      singleRun <= 1'b0;
    end else if (!enable) begin
      running   <= 1'b0;
      singleRun <= 1'b0;
    end else if (startAny) begin
      running   <= 1'b1;
      singleRun <= !startCont;   // continuous wins when both strobe
    end else if (endHit && singleRun) begin
      running   <= 1'b0;
    end
  end

  always_comb begin
    strobe.cntClear  = !enable || startAny || endHit;
    strobe.cntInc    = running && !wrapHit;
    strobe.periodEnd = endHit;
    strobe.running   = running;
    strobe.flush     = !enable;
  end

endmodule

// File: rtl/tmr_wave_dp.sv
module tmr_wave_dp
  import tmr_wave_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  wave_strobe_t     strobe,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic             wrapHit,
  output logic             waveOut,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] perActive,
  output logic [CNT_W-1:0] cmpActive,
  output logic             pend,
  output logic             setLatch,
  output logic             cfgMode,
  output logic             cfgPol
);

  localparam logic [CNT_W-1:0] MIN_PERIOD = CNT_W'(1);

  logic [CNT_W-1:0] perShadow;
  logic [CNT_W-1:0] cmpShadow;
  logic [CNT_W-1:0] perEff;
  logic [CFG_W-1:0] cfg;
  logic             deferWr;
  logic             wrPer;
  logic             wrCmp;
  logic             match;
  logic             level;

  assign cfgMode = cfg[CFG_MODE_BIT];
  assign cfgPol  = cfg[CFG_POL_BIT];
  assign perEff  = (perActive == '0) ? MIN_PERIOD : perActive;
  assign wrapHit = (count >= perEff);
  assign deferWr = cfg[CFG_PRE_BIT] && strobe.running;
  assign wrPer   = wrEn && (wrAddr == ADDR_PERIOD);
  assign wrCmp   = wrEn && (wrAddr == ADDR_COMPARE);
  assign match   = strobe.running && (count > cmpActive);
  assign level   = match || (cfgMode && setLatch);

  // counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                count <= '0;
    else if (strobe.cntClear) count <= '0;
    else if (strobe.cntInc)   count <= count + CNT_W'(1);
  end

  // working and shadow registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perActive <= '0;
      cmpActive <= '0;
      perShadow <= '0;
      cmpShadow <= '0;
      cfg       <= '0;
    end else begin
      if (strobe.flush) begin
        perShadow <= perActive;
        cmpShadow <= cmpActive;
      end
      if (strobe.periodEnd && pend) begin
        perActive <= perShadow;
        cmpActive <= cmpShadow;
      end
      if (wrPer) begin
        perShadow <= wrData;
        if (!deferWr) perActive <= wrData;
      end
      if (wrCmp) begin
        cmpShadow <= wrData;
        if (!deferWr) cmpActive <= wrData;
      end
      if (wrEn && (wrAddr == ADDR_CONFIG)) cfg <= wrData[CFG_W-1:0];
    end
  end

  // deferred-transfer flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           pend <= 1'b0;
    else if (strobe.flush)               pend <= 1'b0;
    else if ((wrPer || wrCmp) && deferWr) pend <= 1'b1;
    else if (strobe.periodEnd)           pend <= 1'b0;
  end

  // set-once latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   setLatch <= 1'b0;
    else if (strobe.flush)       setLatch <= 1'b0;
    else if (match && cfgMode)   setLatch <= 1'b1;
  end

  // registered output with polarity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waveOut <= 1'b0;
    else       waveOut <= level ^ cfgPol;
  end

endmodule

// File: rtl/tmr_wave_gen.sv
module tmr_wave_gen
  import tmr_wave_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             startCont,
  input  logic             startSingle,
  output logic             waveOut
);

  wave_strobe_t     strobe;
  logic             singleRun;
  logic             wrapHit;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] perActive;
  logic [CNT_W-1:0] cmpActive;
  logic             pend;
  logic             setLatch;
  logic             cfgMode;
  logic             cfgPol;

  tmr_wave_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .startCont   (startCont),
    .startSingle (startSingle),
    .wrapHit     (wrapHit),
    .strobe      (strobe),
    .singleRun   (singleRun)
  );

  tmr_wave_dp #(.CNT_W(CNT_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .wrapHit   (wrapHit),
    .waveOut   (waveOut),
    .count     (count),
    .perActive (perActive),
    .cmpActive (cmpActive),
    .pend      (pend),
    .setLatch  (setLatch),
    .cfgMode   (cfgMode),
    .cfgPol    (cfgPol)
  );

endmodule

// File: rtl/tmr_wave_chk.sv
module tmr_wave_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             wrEn,
  input logic             running,
  input logic             singleRun,
  input logic             wrapHit,
  input logic             periodEnd,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] perActive,
  input logic [CNT_W-1:0] cmpActive,
  input logic             pend,
  input logic             setLatch,
  input logic             cfgMode,
  input logic             cfgPol,
  input logic             waveOut
);

  assert_single_stop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && running && singleRun && wrapHit) |=> !running);

  assert_flush_state_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!running && count == '0 && !setLatch && !pend));

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(running) && !$past(setLatch)) |-> (waveOut == $past(cfgPol)));

  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (setLatch && cfgMode && enable) |=> (setLatch && waveOut != $past(cfgPol)));

  assert_defer_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pend && !periodEnd && enable && !wrEn) |=> ($stable(perActive) && $stable(cmpActive)));

endmodule

bind tmr_wave_gen tmr_wave_chk #(.CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .wrEn      (wrEn),
  .running   (strobe.running),
  .singleRun (singleRun),
  .wrapHit   (wrapHit),
  .periodEnd (strobe.periodEnd),
  .count     (count),
  .perActive (perActive),
  .cmpActive (cmpActive),
  .pend      (pend),
  .setLatch  (setLatch),
  .cfgMode   (cfgMode),
  .cfgPol    (cfgPol),
  .waveOut   (waveOut)
);

// File: tb/test_tmr_wave_gen.sv
module test_tmr_wave_gen;

  localparam int CNT_W      = 8;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic             wrEn = 1'b0;
  logic [1:0]       wrAddr = '0;
  logic [CNT_W-1:0] wrData = '0;
  logic             startCont = 1'b0;
  logic             startSingle = 1'b0;
  logic             waveOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_wave_gen #(.CNT_W(CNT_W)) i_tmr_wave_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .startCont(startCont), .startSingle(startSingle),
    .waveOut(waveOut)
  );

  task automatic chk(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s at %0t: waveOut=%b expected=%b", req, $time, act, exp);
    end
  endtask

  function automatic logic pwmExp(int k, int p, int c);
    return ((k - 1) % (p + 1)) > c;
  endfunction

  task automatic wrReg(logic [1:0] a, int d);
    wrEn = 1'b1; wrAddr = a; wrData = CNT_W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setup(int mode, int pol, int pre, int p, int c);
    enable = 1'b0;
    @(negedge clk);
    wrReg(2'd2, mode | (pol << 1) | (pre << 2));
    wrReg(2'd0, p);
    wrReg(2'd1, c);
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic startRun(bit single);
    if (single) startSingle = 1'b1; else startCont = 1'b1;
    @(negedge clk);
    startCont = 1'b0; startSingle = 1'b0;
  endtask

  task automatic testReset();
    chk("R12 reset output", waveOut, 1'b0);
  endtask

  task automatic testPwm(int p, int c, int pol);
    setup(0, pol, 0, p, c);
    startRun(0);
    for (int k = 1; k <= 3 * (p + 1); k++) begin
      @(negedge clk);
      chk("R1 continuous pwm", waveOut, pwmExp(k, p, c) ^ pol[0]);
    end
  endtask

  task automatic testSingle();
    setup(0, 0, 0, 4, 1);
    for (int r = 0; r < 2; r++) begin
      startRun(1);
      for (int k = 1; k <= 12; k++) begin
        @(negedge clk);
        chk("R2 single pulse", waveOut, (k <= 5) ? pwmExp(k, 4, 1) : 1'b0);
      end
    end
  endtask

  task automatic testSetOnce();
    setup(1, 0, 0, 5, 2);
    startRun(0);
    for (int k = 1; k <= 18; k++) begin
      @(negedge clk);
      chk("R3 set once latch", waveOut, k >= 4);
    end
  endtask

  task automatic testPolarity();
    setup(0, 0, 0, 3, 0);
    enable = 1'b0;
    @(negedge clk);
    chk("R4 idle level before change", waveOut, 1'b0);
    wrReg(2'd2, 2);
    chk("R4 not yet inverted on write edge", waveOut, 1'b0);
    @(negedge clk);
    chk("R4 inverted idle level", waveOut, 1'b1);
    wrReg(2'd2, 0);
    @(negedge clk);
    chk("R4 restored idle level", waveOut, 1'b0);
  endtask

  task automatic testUpdate(int pre);
    setup(0, 0, pre, 7, 6);
    startRun(0);
    for (int k = 1; k <= 24; k++) begin
      int cUse;
      @(negedge clk);
      if (pre == 0) cUse = (k >= 3) ? 2 : 6;
      else          cUse = (k >= 9) ? 2 : 6;
      if (pre == 0) chk("R5 immediate update", waveOut, pwmExp(k, 7, cUse));
      else          chk("R6 R7 deferred update", waveOut, pwmExp(k, 7, cUse));
      if (k == 1) begin wrEn = 1'b1; wrAddr = 2'd1; wrData = CNT_W'(2); end
      if (k == 2) wrEn = 1'b0;
    end
  endtask

  task automatic testCmpHigh(int c);
    setup(0, 0, 0, 4, c);
    startRun(0);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      chk("R8 compare not below period", waveOut, 1'b0);
    end
  endtask

  task automatic testMinPeriod();
    setup(0, 0, 0, 0, 0);
    startRun(0);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk("R9 period zero clamps to two clocks", waveOut, pwmExp(k, 1, 0));
    end
  endtask

  task automatic testFlush();
    setup(1, 0, 0, 3, 0);
    startRun(0);
    repeat (6) @(negedge clk);
    chk("R10 latched before flush", waveOut, 1'b1);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 inactive after disable", waveOut, 1'b0);
    enable = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10 latch and run cleared", waveOut, 1'b0);
    end
    // pending transfer discarded
    setup(0, 0, 1, 7, 6);
    startRun(0);
    @(negedge clk);
    wrReg(2'd1, 2);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    startRun(0);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      chk("R10 deferred value discarded", waveOut, pwmExp(k, 7, 6));
    end
  endtask

  task automatic testStartIgnored();
    setup(0, 0, 0, 3, 0);
    enable = 1'b0;
    startRun(0);
    startRun(1);
    enable = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R11 start ignored while disabled", waveOut, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPwm(5, 2, 0);
    testPwm(3, 0, 1);
    testSingle();
    testSetOnce();
    testPolarity();
    testUpdate(0);
    testUpdate(1);
    testCmpHigh(4);
    testCmpHigh(200);
    testMinPeriod();
    testFlush();
    testStartIgnored();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule